// File: doc/BRIEF.md
# Multi-Format Audio Serial Output Port

This block turns a stereo pair of 24-bit PCM samples into a serial audio stream. The stream has a bit clock, a data line and a left/right word clock. The framing format and the word length come from two 2-bit control fields. Both fields are taken at the start of every frame, so a change never breaks a frame that is already being sent.

The block runs from one system clock. The bit clock is that clock divided by two. A frame is 64 bit clocks long, with 32 slots for each channel.

- In master mode the block counts the frame itself and drives the word clock.
- In slave mode the word clock is an input. Each level change of that input moves the slot counter to the start of the matching channel.

Samples arrive on a valid/ready handshake that is offered once per frame. When no sample is waiting at a frame start, the frame carries silence.

Top module: `asop_tx`

## Requirements
- R1: Format code 00 is left-justified. The left word is sent while the word clock is high, and each word's MSB is in the first slot of its half-frame (slot 0 or slot 32).
- R2: Format code 01 is I2S. The left word is sent while the word clock is low, and each MSB is one slot after the start of its half-frame (slot 1 or slot 33).
- R3: Format code 11 is right-justified. The word clock is high for the left half, and each word's LSB is in the last slot of its half-frame (slot 31 or slot 63).
- R4: Format code 10 is TDM. In master mode the word clock is a pulse exactly 32 bit clocks wide at the start of the frame, and the data is placed as in R1. In slave mode only a rising edge of the word clock restarts the frame; a falling edge does not move the slot counter.
- R5: The word-length code selects the word size: 00 = 24 bits, 01 = 20 bits, 10 = 18 bits, 11 = 16 bits. The most significant bits of the 24-bit input are used. Every slot outside the word is 0.
- R6: While rst_ni is low, bclk_o, sdata_o, lrck_o and ready_o are 0. The format and length registers reset to left-justified, 24 bits.
- R7: bclk_o is clk_i divided by two. sdata_o and the slot counter change only when bclk_o falls.
- R8: A frame is 64 bit clocks. In master mode the word clock has period 64 and changes level only at slot 0 or slot 32, which gives a 50% duty cycle.
- R9: ready_o is high for exactly one clk_i cycle at each frame start. If valid_i is high in that cycle, left_i and right_i are taken. Otherwise the frame sends zeros.
- R10: In slave mode lrck_o is 0 and lrck_oe_o is 0. A level change on lrck_i, sampled on the rising bit clock, moves the next slot to the start of the matching channel: slot 0 for the left channel, slot 32 for the right. Output therefore lags the word-clock edge by one bit clock.
- R11: fmt_i, wl_i, left_i and right_i are taken only at a frame start. Changes during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (drives the word clock), 0 = slave |
| fmt_i | input | 2 | Framing format code |
| wl_i | input | 2 | Word-length code |
| valid_i | input | 1 | A sample pair is present |
| left_i | input | 24 | Left sample, MSB-aligned |
| right_i | input | 24 | Right sample, MSB-aligned |
| ready_o | output | 1 | Frame start; the pair is taken now |
| bclk_o | output | 1 | Bit clock |
| lrck_i | input | 1 | Word clock input in slave mode |
| lrck_o | output | 1 | Word clock output in master mode |
| lrck_oe_o | output | 1 | Output enable for the word clock pad |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions check on every cycle that:
- data and the slot counter move only on falling bit-clock edges;
- the master word clock toggles only on half-frame boundaries;
- no data bit appears past the longest word in the non-right-justified formats, and none before the earliest right-justified start;
- a handshake at a frame start loads the sample.

Only the bench scenarios can show the exact slot of each bit for every format and length, the zero fill, the silence frame after an underrun, the immunity of a running frame to control changes, and the slave-mode restart points, including the falling edge that TDM ignores.

// File: rtl/asop_pkg.sv
package asop_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RJ  = 2'b11
  } fmt_e;

  function automatic int wl_bits(input logic [1:0] code);
    case (code)
      2'b00:   wl_bits = 24;
      2'b01:   wl_bits = 20;
      2'b10:   wl_bits = 18;
      default: wl_bits = 16;
    endcase
  endfunction
endpackage

// File: rtl/asop_bit_timer.sv
module asop_bit_timer (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic adv_o,
  output logic rise_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign bclk_o = phase_q;
  assign adv_o  = phase_q;   // next edge drops the bit clock
  assign rise_o = ~phase_q;  // next edge raises the bit clock
endmodule

// File: rtl/asop_slot_ctr.sv
module asop_slot_ctr
  import asop_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int CW = $clog2(2 * SLOT_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          rise_i,
  input  logic          master_i,
  input  fmt_e          fmt_cur_i,
  input  fmt_e          fmt_nxt_i,
  input  logic          lrck_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          frame_start_o,
  output logic          lrck_o
);
  localparam logic [CW-1:0] HALF = CW'(SLOT_W);

  logic [CW-1:0] cnt_q, cnt_inc, cnt_d;
  logic          lr_s_q, lr_p_q, lr_edge, lrck_q, lrck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_s_q <= 1'b0;
      lr_p_q <= 1'b0;
    end else begin
      if (rise_i) lr_s_q <= lrck_i;
      if (adv_i)  lr_p_q <= lr_s_q;
    end
  end

  assign lr_edge = lr_s_q ^ lr_p_q;
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_inc;
    if (!master_i && lr_edge) begin
      case (fmt_cur_i)
        FMT_I2S: cnt_d = lr_s_q ? HALF : '0;
        FMT_TDM: cnt_d = lr_s_q ? '0 : cnt_inc;
        default: cnt_d = lr_s_q ? '0 : HALF;
      endcase
    end
  end

  always_comb begin
    lrck_d = 1'b0;
    if (master_i) lrck_d = (fmt_nxt_i == FMT_I2S) ? cnt_d[CW-1] : ~cnt_d[CW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      lrck_q <= 1'b0;
    end else if (adv_i) begin
      cnt_q  <= cnt_d;
      lrck_q <= lrck_d;
    end
  end

  assign cnt_o         = cnt_q;
  assign cnt_nxt_o     = cnt_d;
  assign frame_start_o = adv_i && (cnt_d == '0);
  assign lrck_o        = lrck_q;

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));

  // R8
  lrck_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) && (lrck_q != $past(lrck_q)) |-> cnt_q[CW-2:0] == '0);
endmodule

// File: rtl/asop_bit_sel.sv
module asop_bit_sel
  import asop_pkg::*;
#(
  parameter int SLOT_W = 32,
  localparam int PW = $clog2(SLOT_W)
) (
  input  fmt_e                fmt_i,
  input  logic [1:0]          wl_i,
  input  logic [PW-1:0]       pos_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic                bit_o
);
  int wbits, off, q;
  logic [SAMPLE_W-1:0] sh;

  always_comb begin
    wbits = wl_bits(wl_i);
    case (fmt_i)
      FMT_I2S: off = 1;
      FMT_RJ:  off = SLOT_W - wbits;
      default: off = 0;
    endcase
    q     = int'(pos_i) - off;
    sh    = word_i << q;
    bit_o = (q >= 0 && q < wbits) ? sh[SAMPLE_W-1] : 1'b0;
  end
endmodule

// File: rtl/asop_tx.sv
module asop_tx
  import asop_pkg::*;
#(
  parameter int SLOT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wl_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic                bclk_o,
  input  logic                lrck_i,
  output logic                lrck_o,
  output logic                lrck_oe_o,
  output logic                sdata_o
);
  localparam int CW = $clog2(2 * SLOT_W);
  localparam int PW = CW - 1;
  localparam int NCH = 2;

  logic          adv, rise, frame_start, bit_d, sdata_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  fmt_e          fmt_q, fmt_nxt;
  logic [1:0]    wl_q, wl_nxt;
  logic [SAMPLE_W-1:0] in_w  [NCH];
  logic [SAMPLE_W-1:0] smp_q [NCH];
  logic [SAMPLE_W-1:0] smp_nxt [NCH];

  asop_bit_timer u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_o (bclk_o),
    .adv_o  (adv),
    .rise_o (rise)
  );

  asop_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .adv_i         (adv),
    .rise_i        (rise),
    .master_i      (master_i),
    .fmt_cur_i     (fmt_q),
    .fmt_nxt_i     (fmt_nxt),
    .lrck_i        (lrck_i),
    .cnt_o         (cnt_q),
    .cnt_nxt_o     (cnt_nxt),
    .frame_start_o (frame_start),
    .lrck_o        (lrck_o)
  );

  assign fmt_nxt = frame_start ? fmt_e'(fmt_i) : fmt_q;
  assign wl_nxt  = frame_start ? wl_i : wl_q;
  assign in_w[0] = left_i;
  assign in_w[1] = right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign smp_nxt[c] = frame_start ? (valid_i ? in_w[c] : '0) : smp_q[c];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_q[c] <= '0;
      else         smp_q[c] <= smp_nxt[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q <= FMT_LJ;
      wl_q  <= 2'b00;
    end else begin
      fmt_q <= fmt_nxt;
      wl_q  <= wl_nxt;
    end
  end

  asop_bit_sel #(.SLOT_W(SLOT_W)) u_sel (
    .fmt_i  (fmt_nxt),
    .wl_i   (wl_nxt),
    .pos_i  (cnt_nxt[PW-1:0]),
    .word_i (smp_nxt[cnt_nxt[CW-1]]),
    .bit_o  (bit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sdata_q <= 1'b0;
    else if (adv) sdata_q <= bit_d;
  end

  assign sdata_o   = sdata_q;
  assign ready_o   = frame_start;
  assign lrck_oe_o = master_i;

  // R7
  sdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(sdata_o));

  // R5
  word_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_o && (fmt_q != FMT_RJ) |-> int'(cnt_q[PW-1:0]) <= SAMPLE_W);

  // R3
  rj_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_o && (fmt_q == FMT_RJ) |-> int'(cnt_q[PW-1:0]) >= SLOT_W - SAMPLE_W);

  // R9
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && valid_i |=> smp_q[0] == $past(left_i) && smp_q[1] == $past(right_i));
endmodule

// File: tb/sim_asop_tx.sv
module sim_asop_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        master_i = 1'b1;
  logic [1:0]  fmt_i = 2'b00, wl_i = 2'b00;
  logic        valid_i = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic        lrck_i = 1'b0;
  logic        ready_o, bclk_o, lrck_o, lrck_oe_o, sdata_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asop_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .fmt_i(fmt_i), .wl_i(wl_i),
    .valid_i(valid_i), .left_i(left_i), .right_i(right_i), .ready_o(ready_o),
    .bclk_o(bclk_o), .lrck_i(lrck_i), .lrck_o(lrck_o), .lrck_oe_o(lrck_oe_o),
    .sdata_o(sdata_o)
  );

  // {fmt, wl, left, right}
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {2'b00, 2'b00, 24'hA5C3F1, 24'h3C5A96},
    {2'b01, 2'b00, 24'h800001, 24'h7FFFFE},
    {2'b11, 2'b00, 24'h123456, 24'hFEDCBA},
    {2'b10, 2'b00, 24'hC0FFEE, 24'h0BEEF1},
    {2'b00, 2'b11, 24'hABCDEF, 24'h13579B},
    {2'b01, 2'b01, 24'hF0F0F0, 24'h0F0F0F},
    {2'b11, 2'b11, 24'hFFFFFF, 24'h000001},
    {2'b11, 2'b10, 24'h9ABCDE, 24'h123456}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string fmt_req(input logic [1:0] f);
    case (f)
      2'b00:   fmt_req = "R1";
      2'b01:   fmt_req = "R2";
      2'b10:   fmt_req = "R4";
      default: fmt_req = "R3";
    endcase
  endfunction

  function automatic logic [63:0] exp_data(input logic [1:0] f, w, input logic [23:0] l, r);
    int n, st;
    n  = (w == 2'b00) ? 24 : (w == 2'b01) ? 20 : (w == 2'b10) ? 18 : 16;
    st = (f == 2'b01) ? 1 : (f == 2'b11) ? 32 - n : 0;
    exp_data = '0;
    for (int s = 0; s < 64; s++) begin
      logic [23:0] wd;
      int p;
      wd = (s >= 32) ? r : l;
      p  = s % 32;
      if (p >= st && p < st + n) exp_data[s] = wd[23 - (p - st)];
    end
  endfunction

  function automatic logic [63:0] exp_lrck(input logic [1:0] f);
    for (int s = 0; s < 64; s++) exp_lrck[s] = (f == 2'b01) ? (s >= 32) : (s < 32);
  endfunction

  task automatic wait_ready();
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ready_o && k < 400);
    check(ready_o, "R9 frame start seen", {63'd0, ready_o}, 64'd1);
  endtask

  task automatic run_frame(input logic [1:0] f, w, input logic [23:0] l, r, input bit vld,
                           input bit scramble, output logic [63:0] sd, lr, bc);
    fmt_i = f; wl_i = w; left_i = l; right_i = r; valid_i = vld;
    wait_ready();
    if (scramble) begin
      @(posedge clk); #1;
      fmt_i = ~f; wl_i = ~w; left_i = ~l; right_i = ~r;
    end
    for (int s = 0; s < 64; s++) begin
      @(negedge clk);
      sd[s] = sdata_o; lr[s] = lrck_o; bc[s] = bclk_o;
      if (s < 63) @(negedge clk);
    end
  endtask

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] sd, lr, bc, e;
    repeat (4) @(negedge clk);
    // R6 reset state
    check(bclk_o == 0, "R6 bclk in reset", {63'd0, bclk_o}, 64'd0);
    check(sdata_o == 0, "R6 sdata in reset", {63'd0, sdata_o}, 64'd0);
    check(lrck_o == 0, "R6 lrck in reset", {63'd0, lrck_o}, 64'd0);
    check(ready_o == 0, "R6 ready in reset", {63'd0, ready_o}, 64'd0);
    rst_ni = 1'b1;

    // table walk: data (R1..R5), word clock (R8), bit clock phase (R7)
    for (int i = 0; i < NV; i++) begin
      logic [1:0] f, w;
      f = VEC[i][51:50]; w = VEC[i][49:48];
      run_frame(f, w, VEC[i][47:24], VEC[i][23:0], 1'b1, 1'b0, sd, lr, bc);
      e = exp_data(f, w, VEC[i][47:24], VEC[i][23:0]);
      check(sd == e, (w != 0) ? {fmt_req(f), " R5 data"} : {fmt_req(f), " data"}, sd, e);
      check(lr == exp_lrck(f), (f == 2'b10) ? "R4 R8 word clock" : "R8 word clock",
            lr, exp_lrck(f));
      check(bc == '0, "R7 bit clock low after data change", bc, 64'd0);
    end

    // R11: controls and data changed after the frame start are not used
    run_frame(2'b00, 2'b00, 24'h5A0FF3, 24'hC3300C, 1'b1, 1'b1, sd, lr, bc);
    e = exp_data(2'b00, 2'b00, 24'h5A0FF3, 24'hC3300C);
    check(sd == e, "R11 mid-frame change ignored", sd, e);
    check(lr == exp_lrck(2'b00), "R11 word clock unchanged", lr, exp_lrck(2'b00));

    // R9: one-cycle ready, underrun frame is silent
    fmt_i = 2'b00; wl_i = 2'b00; valid_i = 1'b1;
    wait_ready();
    @(negedge clk);
    check(ready_o == 0, "R9 ready one cycle wide", {63'd0, ready_o}, 64'd0);
    run_frame(2'b00, 2'b00, 24'hFFFFFF, 24'hFFFFFF, 1'b0, 1'b0, sd, lr, bc);
    check(sd == '0, "R9 underrun sends zeros", sd, 64'd0);

    // R10: slave mode, left-justified
    master_i = 1'b0; lrck_i = 1'b0; valid_i = 1'b1;
    fmt_i = 2'b00; wl_i = 2'b00; left_i = 24'hC3A50F; right_i = 24'h5A5A5A;
    repeat (300) @(negedge clk);
    check(lrck_oe_o == 0, "R10 pad disabled", {63'd0, lrck_oe_o}, 64'd0);
    check(lrck_o == 0, "R10 lrck_o low", {63'd0, lrck_o}, 64'd0);
    for (int m = 0; m < 2; m++) begin
      logic [63:0] got, want;
      fmt_i = (m == 0) ? 2'b00 : 2'b10;
      repeat (300) @(negedge clk);  // wraps load the format
      wait_ready();
      repeat (20) @(negedge clk);
      lrck_i = 1'b1;
      wait_ready();
      got = '0; want = '0;
      for (int s = 0; s < 6; s++) begin
        @(negedge clk);
        got[s] = sdata_o; want[s] = left_i[23 - s];
        if (s < 5) @(negedge clk);
      end
      lrck_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      got[6]  = sdata_o;
      want[6] = (m == 0) ? right_i[23] : left_i[17];
      check(got == want, (m == 0) ? "R10 slave restart to left/right" : "R4 R10 TDM falling edge ignored",
            got, want);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule